// File: doc/BRIEF.md
# Colour Lookup Table CPU Access Port

This block holds a colour lookup table of 256 entries. Each entry is made of three 6-bit colour components. A processor reaches the table through a small register port. It loads a start entry for writing or a start entry for reading, then moves one component per access through a single data register. A hidden component counter steps through red, green and blue. After blue it advances whichever entry pointer is in use, so a whole table streams through the data register with no further address writes.

On the display side, an 8-bit pixel index is ANDed with a programmable mask. The result addresses the table, and the 18-bit colour for that index appears one clock later. A state register tells software whether the port was last set up for reading or for writing.

Top module: `palette_port`

## Requirements
- R1: After reset the port is in write mode (state reads 3), both entry pointers are 0, the component counter is at red, and the mask is FFh.
- R2: A write to select 2 loads the write pointer, puts the port in write mode and returns the component counter to red. A read of select 2 returns the current write pointer.
- R3: A write to select 1 loads the read pointer, puts the port in read mode and returns the component counter to red. The write pointer is left unchanged.
- R4: A write to select 3 stores data bits 5:0 as the current component of the entry at the write pointer. Bits 7:6 are dropped. Components go in the order red, green, blue, and the write pointer increments after blue.
- R5: A read of select 3 returns the current component of the entry at the read pointer in bits 5:0, with bits 7:6 zero. The order is red, green, blue, and the read pointer increments after blue.
- R6: Both pointers wrap from 255 to 0.
- R7: A read of select 1 returns 0 in read mode and 3 in write mode.
- R8: Select 0 is the pixel mask. It can be written and read back, and it is ANDed with every pixel index before the lookup.
- R9: `pix_rgb` carries the colour of the entry (`pix_idx` AND mask) one clock after `pix_idx` is presented. Red is in bits 17:12, green in 11:6 and blue in 5:0.
- R10: Writing 0 to select 2 and then 768 data bytes loads every entry of the table.
- R11: Every read returns its data with `cpu_rvalid` high in the cycle after `cpu_rd`. When `cpu_wr` and `cpu_rd` are high together, the write takes place and the read is dropped (`cpu_rvalid` stays low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_sel | input | 2 | Register select: 0 mask, 1 read pointer / state, 2 write pointer, 3 data |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid while `cpu_rvalid` is high |
| cpu_rvalid | output | 1 | Read data valid, one cycle after `cpu_rd` |
| pix_idx | input | 8 | Pixel index from the display pipeline |
| pix_rgb | output | 18 | Looked-up colour {red, green, blue} |

## Verification
The assertions check the stepping rules on every cycle. These are: the component counter never leaves its three legal values, a pointer moves by exactly one only after a blue access and holds otherwise, each pointer load resets the counter and sets the mode, and read-valid timing follows the strobes. The bench's scenarios are needed for stored contents and data values. These include what a full 768-byte load leaves in the table, the masked display lookup and its latency, readback through the data register, and the wrap at entry 255.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    COMP_RED = 2'd0,
    COMP_GRN = 2'd1,
    COMP_BLU = 2'd2
  } comp_e;

  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_RADDR = 2'd1,
    SEL_WADDR = 2'd2,
    SEL_DATA  = 2'd3
  } port_sel_e;

  localparam logic [7:0] STATE_READ  = 8'h00;
  localparam logic [7:0] STATE_WRITE = 8'h03;
endpackage

// File: rtl/pal_ram.sv
// One colour component plane: CPU port (read/write) and display port (read).
module pal_ram #(
  parameter int AW = 8,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] a_q;
  logic [DW-1:0] b_q;

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (a_re) a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_q <= mem[b_addr];
  end

  assign a_rdata = a_q;
  assign b_rdata = b_q;
endmodule

// File: rtl/pal_seq.sv
// Entry pointers, component counter and access mode.
module pal_seq
  import pal_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_waddr,
  input  logic          set_raddr,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output comp_e         sub,
  output logic          wr_mode
);
  comp_e sub_next;

  always_comb begin
    case (sub)
      COMP_RED: sub_next = COMP_GRN;
      COMP_GRN: sub_next = COMP_BLU;
      default:  sub_next = COMP_RED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waddr   <= '0;
      raddr   <= '0;
      sub     <= COMP_RED;
      wr_mode <= 1'b1;
    end else if (set_waddr) begin
      waddr   <= addr_in;
      sub     <= COMP_RED;
      wr_mode <= 1'b1;
    end else if (set_raddr) begin
      raddr   <= addr_in;
      sub     <= COMP_RED;
      wr_mode <= 1'b0;
    end else if (data_wr || data_rd) begin
      sub <= sub_next;
      if (sub == COMP_BLU) begin
        if (data_wr) waddr <= waddr + 1'b1;
        else         raddr <= raddr + 1'b1;
      end
    end
  end

  // R4 / R5: the counter only takes the three component codes
  p_sub_legal_r4: assert property (@(posedge clk) disable iff (rst)
    sub != comp_e'(2'd3));

  // R4 / R6: write pointer steps by one (modulo) after blue, holds before it
  p_wptr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (data_wr && sub == COMP_BLU) |=> waddr == AW'($past(waddr) + 1'b1));
  p_wptr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (data_wr && sub != COMP_BLU) |=> $stable(waddr));

  // R5 / R6: read pointer behaves the same way for data reads
  p_rptr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (data_rd && sub == COMP_BLU) |=> raddr == AW'($past(raddr) + 1'b1));
  p_rptr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (data_rd && sub != COMP_BLU) |=> $stable(raddr));

  // R2: a write pointer load restarts at red in write mode
  p_wload_r2: assert property (@(posedge clk) disable iff (rst)
    set_waddr |=> (sub == COMP_RED && wr_mode && waddr == $past(addr_in)));

  // R3: a read pointer load restarts at red in read mode, write pointer kept
  p_rload_r3: assert property (@(posedge clk) disable iff (rst)
    set_raddr |=> (sub == COMP_RED && !wr_mode && $stable(waddr)));
endmodule

// File: rtl/palette_port.sv
module palette_port
  import pal_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int COMP_W = 6,
  parameter int BUS_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_wr,
  input  logic                cpu_rd,
  input  logic [1:0]          cpu_sel,
  input  logic [BUS_W-1:0]    cpu_wdata,
  output logic [BUS_W-1:0]    cpu_rdata,
  output logic                cpu_rvalid,
  input  logic [ADDR_W-1:0]   pix_idx,
  output logic [3*COMP_W-1:0] pix_rgb
);
  localparam int NCOMP = 3;

  port_sel_e sel;
  logic      wr_go, rd_go;
  logic      set_waddr, set_raddr, data_wr, data_rd;

  logic [ADDR_W-1:0] waddr, raddr, ram_addr, lut_idx;
  logic [ADDR_W-1:0] mask_q;
  comp_e             sub;
  logic              wr_mode;

  logic [COMP_W-1:0] cpu_comp [NCOMP];
  logic [COMP_W-1:0] pix_comp [NCOMP];

  port_sel_e         rsel_q;
  comp_e             rsub_q;
  logic [BUS_W-1:0]  reg_q;
  logic [COMP_W-1:0] comp_sel;

  assign sel   = port_sel_e'(cpu_sel);
  assign wr_go = cpu_wr;
  assign rd_go = cpu_rd && !cpu_wr;

  assign set_waddr = wr_go && sel == SEL_WADDR;
  assign set_raddr = wr_go && sel == SEL_RADDR;
  assign data_wr   = wr_go && sel == SEL_DATA;
  assign data_rd   = rd_go && sel == SEL_DATA;

  pal_seq #(.AW(ADDR_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .set_waddr (set_waddr),
    .set_raddr (set_raddr),
    .data_wr   (data_wr),
    .data_rd   (data_rd),
    .addr_in   (cpu_wdata[ADDR_W-1:0]),
    .waddr     (waddr),
    .raddr     (raddr),
    .sub       (sub),
    .wr_mode   (wr_mode)
  );

  assign ram_addr = data_wr ? waddr : raddr;
  assign lut_idx  = pix_idx & mask_q;

  for (genvar c = 0; c < NCOMP; c++) begin : g_plane
    pal_ram #(.AW(ADDR_W), .DW(COMP_W)) u_ram (
      .clk     (clk),
      .a_we    (data_wr && sub == comp_e'(c)),
      .a_re    (data_rd && sub == comp_e'(c)),
      .a_addr  (ram_addr),
      .a_wdata (cpu_wdata[COMP_W-1:0]),
      .a_rdata (cpu_comp[c]),
      .b_addr  (lut_idx),
      .b_rdata (pix_comp[c])
    );
  end

  assign pix_rgb = {pix_comp[0], pix_comp[1], pix_comp[2]};

  always_ff @(posedge clk) begin
    if (rst)                          mask_q <= '1;
    else if (wr_go && sel == SEL_MASK) mask_q <= cpu_wdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rvalid <= 1'b0;
      rsel_q     <= SEL_MASK;
      rsub_q     <= COMP_RED;
      reg_q      <= '0;
    end else begin
      cpu_rvalid <= rd_go;
      if (rd_go) begin
        rsel_q <= sel;
        rsub_q <= sub;
        case (sel)
          SEL_MASK:  reg_q <= BUS_W'(mask_q);
          SEL_RADDR: reg_q <= BUS_W'(wr_mode ? STATE_WRITE : STATE_READ);
          SEL_WADDR: reg_q <= BUS_W'(waddr);
          default:   reg_q <= '0;
        endcase
      end
    end
  end

  always_comb begin
    case (rsub_q)
      COMP_GRN: comp_sel = cpu_comp[1];
      COMP_BLU: comp_sel = cpu_comp[2];
      default:  comp_sel = cpu_comp[0];
    endcase
  end

  assign cpu_rdata = (rsel_q == SEL_DATA) ? {{(BUS_W-COMP_W){1'b0}}, comp_sel} : reg_q;

  // R11: a lone read strobe yields valid data next cycle
  p_rvalid_r11: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr) |=> cpu_rvalid);
  // R11: a read colliding with a write is dropped
  p_collide_r11: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr || !cpu_rd) |=> !cpu_rvalid);
  // R5: data reads never drive the upper bits
  p_data_upper_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_rvalid && rsel_q == SEL_DATA) |-> cpu_rdata[BUS_W-1:COMP_W] == '0);
endmodule

// File: tb/palette_port_test.sv
`timescale 1ns/1ps
module palette_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [1:0]  cpu_sel = 2'd0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  cpu_rdata;
  logic        cpu_rvalid;
  logic [7:0]  pix_idx = 8'h00;
  logic [17:0] pix_rgb;

  int checks = 0;
  int fails  = 0;
  logic [17:0] model [256];

  always #10 clk = ~clk;

  palette_port uut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  // {rd, sel[1:0], wdata[7:0], expected[7:0]}
  localparam int NVEC = 18;
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, 2'd2, 8'h05, 8'h00},  // R2 load write pointer
    {1'b1, 2'd2, 8'h00, 8'h05},  // R2 read it back
    {1'b1, 2'd1, 8'h00, 8'h03},  // R7 write mode
    {1'b0, 2'd3, 8'hC1, 8'h00},  // R4 red, upper bits dropped
    {1'b0, 2'd3, 8'h22, 8'h00},  // R4 green
    {1'b0, 2'd3, 8'h13, 8'h00},  // R4 blue
    {1'b1, 2'd2, 8'h00, 8'h06},  // R4 pointer advanced
    {1'b0, 2'd1, 8'h05, 8'h00},  // R3 load read pointer
    {1'b1, 2'd1, 8'h00, 8'h00},  // R7 read mode
    {1'b1, 2'd3, 8'h00, 8'h01},  // R5 red
    {1'b1, 2'd3, 8'h00, 8'h22},  // R5 green
    {1'b0, 2'd1, 8'h05, 8'h00},  // R3 reload restarts at red
    {1'b1, 2'd3, 8'h00, 8'h01},  // R3 red again
    {1'b0, 2'd0, 8'h0F, 8'h00},  // R8 mask write
    {1'b1, 2'd0, 8'h00, 8'h0F},  // R8 mask read
    {1'b1, 2'd2, 8'h00, 8'h06},  // R3 write pointer untouched
    {1'b0, 2'd0, 8'hFF, 8'h00},  // R8 restore mask
    {1'b1, 2'd0, 8'h00, 8'hFF}   // R8 mask read
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_sel = s; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] s, output logic [7:0] d, output logic v);
    @(negedge clk);
    cpu_rd = 1'b1; cpu_sel = s;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata; v = cpu_rvalid;
  endtask

  task automatic read_check(input string tag, input logic [1:0] s, input logic [7:0] exp);
    logic [7:0] d;
    logic v;
    do_read(s, d, v);
    check({tag, " valid"}, {31'd0, v}, 32'd1);
    check(tag, {24'd0, d}, {24'd0, exp});
  endtask

  task automatic pix_check(input string tag, input logic [7:0] idx, input logic [17:0] exp);
    @(negedge clk);
    pix_idx = idx;
    @(negedge clk);
    check(tag, {14'd0, pix_rgb}, {14'd0, exp});
  endtask

  function automatic logic [17:0] colour(input int i);
    logic [5:0] r, g, b;
    r = 6'(i);
    g = 6'((i >> 2) ^ 21);
    b = 6'(255 - i);
    return {r, g, b};
  endfunction

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    read_check("R1 state after reset", 2'd1, 8'h03);
    read_check("R1 write pointer after reset", 2'd2, 8'h00);
    read_check("R1 mask after reset", 2'd0, 8'hFF);

    // Vector table: R2 R3 R4 R5 R7 R8
    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][18]) begin
        do_read(VEC[k][17:16], d, v);
        check($sformatf("table vector %0d (R2 R3 R4 R5 R7 R8)", k),
              {23'd0, v, d}, {23'd0, 1'b1, VEC[k][7:0]});
      end else begin
        do_write(VEC[k][17:16], VEC[k][15:8]);
      end
    end

    // R10 full table load through address 0 and 768 bytes
    do_write(2'd2, 8'h00);
    for (int e = 0; e < 256; e++) begin
      model[e] = colour(e);
      do_write(2'd3, {2'b10, model[e][17:12]});
      do_write(2'd3, {2'b01, model[e][11:6]});
      do_write(2'd3, {2'b11, model[e][5:0]});
    end
    read_check("R10 write pointer wrapped after 768 bytes", 2'd2, 8'h00);

    // R9 display lookup, mask FF
    for (int i = 0; i < 256; i += 17)
      pix_check($sformatf("R9 R10 pixel %0d", i), 8'(i), model[i]);
    pix_check("R9 pixel 255", 8'hFF, model[255]);

    // R8 masked lookup
    do_write(2'd0, 8'h0F);
    pix_check("R8 masked F3", 8'hF3, model[8'h03]);
    pix_check("R8 masked 8C", 8'h8C, model[8'h0C]);
    do_write(2'd0, 8'hFF);
    pix_check("R8 mask restored", 8'hF3, model[8'hF3]);

    // R5 readback of one entry through the data register
    do_write(2'd1, 8'h40);
    read_check("R5 entry 40 red", 2'd3, {2'b00, model[8'h40][17:12]});
    read_check("R5 entry 40 green", 2'd3, {2'b00, model[8'h40][11:6]});
    read_check("R5 entry 40 blue", 2'd3, {2'b00, model[8'h40][5:0]});
    read_check("R5 entry 41 red", 2'd3, {2'b00, model[8'h41][17:12]});

    // R6 wrap of the write pointer
    do_write(2'd2, 8'hFF);
    do_write(2'd3, 8'h2A);
    do_write(2'd3, 8'h15);
    do_write(2'd3, 8'h3C);
    model[255] = {6'h2A, 6'h15, 6'h3C};
    read_check("R6 write pointer wrap", 2'd2, 8'h00);
    pix_check("R6 entry 255 rewritten", 8'hFF, model[255]);

    // R6 wrap of the read pointer
    do_write(2'd1, 8'hFF);
    read_check("R6 entry 255 red", 2'd3, 8'h2A);
    read_check("R6 entry 255 green", 2'd3, 8'h15);
    read_check("R6 entry 255 blue", 2'd3, 8'h3C);
    read_check("R6 read wrap to entry 0", 2'd3, {2'b00, model[0][17:12]});

    // R11 simultaneous write and read: write lands, read dropped
    @(negedge clk);
    cpu_wr = 1'b1; cpu_rd = 1'b1; cpu_sel = 2'd0; cpu_wdata = 8'hAA;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
    check("R11 collided read dropped", {31'd0, cpu_rvalid}, 32'd0);
    read_check("R11 collided write applied", 2'd0, 8'hAA);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule